// File: doc/BRIEF.md
# Serial Flash Host Controller

This engine sits between a processor or control state machine and an external serial configuration flash. It can read, program and erase the spare areas of that flash. A caller presents one request at a time on a valid/ready handshake. The request kinds are: read a run of bytes, program up to one page, erase a 64 KB sector, erase the whole array, read the status byte, or write the status byte. The engine then drives chip select, a divided serial clock and the serial command, address and data streams. Program data is pulled from the caller one byte at a time. Read data is returned one byte at a time with a strobe.

Before any command that changes the flash, the engine issues a separate write-enable transaction. After that command it keeps reading the status byte until the busy flag drops, so it does not wait a fixed worst-case time. A poll limit turns a flash that stays busy into an error completion. Requests that would run a program past a page end are refused without touching the bus.

The serial clock half period is a parameter counted in system clocks. It must be chosen so that the flash clock stays at or below 20 MHz.

Top module: `sflash_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and the request side is ready.
- R2: The serial clock idles low whenever chip select is high. Each high phase lasts exactly CLK_HALF system clocks and each low phase lasts at least that long. Outgoing bits are sent MSB first and change only while the clock is low. Incoming bits are captured at the rising clock edge.
- R3: A read sends opcode 0x03 followed by a 3-byte address, most significant byte first, then clocks in the requested number of bytes. A status read sends opcode 0x05 and clocks in one byte.
- R4: Each modifying request is preceded by its own one-byte 0x06 transaction, with chip select high between the two transactions. The modifying requests and their transactions are: program (0x02, 3 address bytes, then data), sector erase (0xD8 plus address), bulk erase (0xC7 alone) and status write (0x01 plus one byte).
- R5: After a modifying transaction the engine repeats one-byte-response 0x05 transactions until the returned bit 0 is 0. It then completes with fail low.
- R6: If POLL_LIMIT consecutive polls all return bit 0 set, the engine stops polling and completes with fail high.
- R7: A program whose low address byte plus its length exceeds 256, a program or read of length 0, or an unknown request code completes one cycle after acceptance with fail high and no chip-select activity. A program ending exactly at a page end is accepted.
- R8: For a program of N bytes, wr_take pulses exactly N times. Each pulse consumes wr_data in request order.
- R9: A read of N bytes, or a status read (N=1), gives exactly N rd_valid pulses carrying the bytes in the order received.
- R10: req_ready is low from acceptance until completion and always while chip select is low. done is a single-cycle pulse.
- R11: A sector erase sends the sector base address: the request address with bits 15:0 cleared.

Request codes on req_op: 0 read, 1 program, 2 sector erase, 3 bulk erase, 4 status read, 5 status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 3 | Request code (see list above) |
| req_addr | input | 24 | Byte address of the request |
| req_len | input | 9 | Byte count for read and program, 1 to 256 |
| req_wdata | input | 8 | Value for a status write |
| wr_data | input | 8 | Next program data byte |
| wr_take | output | 1 | Pulse: wr_data consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: request finished |
| fail | output | 1 | With done: refused or poll timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions guard the properties that hold on every cycle: the clock stays low while deselected, the request side stays blocked during a transaction, done lasts one cycle, fail only appears with done, a refused request leaves the bus untouched, and outgoing data is stable while the clock is high. Other behaviour can only be shown by scenarios run against a behavioural flash model: the write-enable ordering, the exact opcode, address and data bytes, the number of busy polls, the timeout after the poll limit, the sector base address, and the data that a later read returns. Those scenarios compare the decoded transactions and the returned bytes against values worked out from the requirements.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
  typedef enum logic [2:0] {
    REQ_READ = 3'd0, REQ_PROG = 3'd1, REQ_SECT = 3'd2,
    REQ_BULK = 3'd3, REQ_RDST = 3'd4, REQ_WRST = 3'd5
  } req_op_e;

  typedef enum logic [1:0] {PH_WREN, PH_MAIN, PH_POLL} phase_e;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_RDST = 8'h05;
  localparam logic [7:0] CMD_WRST = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_SECT = 8'hD8;
  localparam logic [7:0] CMD_BULK = 8'hC7;

  function automatic logic [7:0] main_cmd(input logic [2:0] op);
    case (op)
      REQ_READ: return CMD_READ;
      REQ_PROG: return CMD_PROG;
      REQ_SECT: return CMD_SECT;
      REQ_BULK: return CMD_BULK;
      REQ_WRST: return CMD_WRST;
      default:  return CMD_RDST;
    endcase
  endfunction

  function automatic logic modifies(input logic [2:0] op);
    return (op == REQ_PROG) || (op == REQ_SECT) || (op == REQ_BULK) || (op == REQ_WRST);
  endfunction

  function automatic logic has_addr(input logic [2:0] op);
    return (op == REQ_READ) || (op == REQ_PROG) || (op == REQ_SECT);
  endfunction

  // bytes in the main transaction, opcode included
  function automatic logic [9:0] main_bytes(input logic [2:0] op, input logic [8:0] len);
    case (op)
      REQ_READ, REQ_PROG: return 10'd4 + {1'b0, len};
      REQ_SECT:           return 10'd4;
      REQ_BULK:           return 10'd1;
      default:            return 10'd2;
    endcase
  endfunction

  function automatic logic page_fits(input logic [7:0] lo, input logic [8:0] len);
    return (len != 9'd0) && (({2'b00, lo} + {1'b0, len}) <= 10'd256);
  endfunction

  function automatic logic [23:0] target_addr(input logic [2:0] op, input logic [23:0] a);
    return (op == REQ_SECT) ? {a[23:16], 16'h0000} : a;
  endfunction
endpackage

// File: rtl/sfh_shift.sv
module sfh_shift #(
  parameter int CLK_HALF = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sr, rs;

  wire half_end = (cnt == CW'(CLK_HALF - 1));
  wire fall_ev  = busy && half_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bitn <= '0; sr <= '0; rs <= '0;
      sck <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sr <= tx; busy <= 1'b1; bitn <= '0; cnt <= '0; sck <= 1'b0;
      end else if (busy) begin
        if (half_end) begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rs  <= {rs[6:0], miso};
          end else begin
            sck <= 1'b0;
            sr  <= {sr[6:0], 1'b0};
            if (bitn == 3'd7) begin
              busy <= 1'b0; done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi = sr[7];
  assign rx   = rs;

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck);
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) (sck && !start) |-> $stable(mosi));
  p_done_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(fall_ev));
endmodule

// File: rtl/sflash_host.sv
module sflash_host
  import sfh_pkg::*;
#(
  parameter int CLK_HALF   = 3,
  parameter int POLL_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_addr,
  input  logic [8:0]  req_len,
  input  logic [7:0]  req_wdata,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        fail,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int GAP_CYC = 2 * CLK_HALF;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int PW      = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_e;

  st_e           st;
  phase_e        ph;
  logic [2:0]    op_q;
  logic [23:0]   addr_q;
  logic [8:0]    len_q;
  logic [7:0]    wd_q;
  logic [9:0]    idx, tot;
  logic          go, stat_busy;
  logic [PW-1:0] polls;
  logic [GW-1:0] gcnt;
  logic [7:0]    txb, b_rx;
  logic          b_busy, b_done;

  sfh_shift #(.CLK_HALF(CLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(go), .tx(txb), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .busy(b_busy), .done(b_done), .rx(b_rx)
  );

  always_comb begin
    case (ph)
      PH_WREN: tot = 10'd1;
      PH_POLL: tot = 10'd2;
      default: tot = main_bytes(op_q, len_q);
    endcase
  end

  always_comb begin
    txb = 8'h00;
    if (idx == 10'd0) begin
      txb = (ph == PH_WREN) ? CMD_WREN : (ph == PH_POLL) ? CMD_RDST : main_cmd(op_q);
    end else if (ph == PH_MAIN) begin
      if (has_addr(op_q) && idx < 10'd4) begin
        case (idx[1:0])
          2'd1:    txb = addr_q[23:16];
          2'd2:    txb = addr_q[15:8];
          default: txb = addr_q[7:0];
        endcase
      end else if (op_q == REQ_WRST) begin
        txb = wd_q;
      end else if (op_q == REQ_PROG) begin
        txb = wr_data;
      end
    end
  end

  wire bad_req   = (req_op > REQ_WRST) ||
                   (req_op == REQ_PROG && !page_fits(req_addr[7:0], req_len)) ||
                   (req_op == REQ_READ && req_len == 9'd0);
  wire reject_ev = (st == S_IDLE) && req_valid && bad_req;
  wire rx_byte   = (ph == PH_POLL) ||
                   (ph == PH_MAIN && ((op_q == REQ_READ && idx >= 10'd4) ||
                                      (op_q == REQ_RDST && idx == 10'd1)));
  wire last_ev   = (st == S_XFER) && b_done && (idx == tot - 10'd1);
  wire gap_end   = (st == S_GAP) && (gcnt == GW'(GAP_CYC - 1));

  assign wr_take   = go && (ph == PH_MAIN) && (op_q == REQ_PROG) && (idx >= 10'd4);
  assign spi_cs_n  = (st != S_XFER);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_MAIN; op_q <= '0; addr_q <= '0; len_q <= '0; wd_q <= '0;
      idx <= '0; go <= 1'b0; stat_busy <= 1'b0; polls <= '0; gcnt <= '0;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; fail <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; rd_valid <= 1'b0; go <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad_req) begin
            done <= 1'b1; fail <= 1'b1;
          end else begin
            op_q <= req_op; addr_q <= target_addr(req_op, req_addr);
            len_q <= req_len; wd_q <= req_wdata;
            ph <= modifies(req_op) ? PH_WREN : PH_MAIN;
            idx <= '0; polls <= '0; st <= S_XFER; go <= 1'b1;
          end
        end
        S_XFER: if (b_done) begin
          if (rx_byte) begin
            if (ph == PH_POLL) stat_busy <= b_rx[0];
            else begin rd_data <= b_rx; rd_valid <= 1'b1; end
          end
          if (idx == tot - 10'd1) begin st <= S_GAP; gcnt <= '0; end
          else begin idx <= idx + 10'd1; go <= 1'b1; end
        end
        S_GAP: if (gap_end) begin
          idx <= '0;
          case (ph)
            PH_WREN: begin ph <= PH_MAIN; st <= S_XFER; go <= 1'b1; end
            PH_MAIN: begin
              if (modifies(op_q)) begin ph <= PH_POLL; st <= S_XFER; go <= 1'b1; end
              else begin st <= S_IDLE; done <= 1'b1; end
            end
            default: begin
              if (!stat_busy) begin st <= S_IDLE; done <= 1'b1; end
              else if (polls == PW'(POLL_LIMIT - 1)) begin st <= S_IDLE; done <= 1'b1; fail <= 1'b1; end
              else begin polls <= polls + 1'b1; st <= S_XFER; go <= 1'b1; end
            end
          endcase
        end else begin
          gcnt <= gcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ready_cs_r10: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> !req_ready);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_sck_cs_r2: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck);
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n) reject_ev |=> (done && fail && spi_cs_n));
  p_fail_done_r6: assert property (@(posedge clk) disable iff (!rst_n) fail |-> done);
  p_poll_cap_r6: assert property (@(posedge clk) disable iff (!rst_n) polls <= PW'(POLL_LIMIT - 1));
  p_take_sel_r8: assert property (@(posedge clk) disable iff (!rst_n) wr_take |-> (!spi_cs_n && !b_busy));
  p_last_gap_r4: assert property (@(posedge clk) disable iff (!rst_n) last_ev |=> spi_cs_n);
endmodule

// File: tb/sim_sflash_host.sv
module sim_sflash_host;
  localparam int HALF = 2, PLIM = 6, BUSYN = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready, wr_take, rd_valid, done, fail;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] req_wdata = '0, wr_data, rd_data;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

  sflash_host #(.CLK_HALF(HALF), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .fail(fail), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] f_mem [0:1023];
  logic [7:0] f_hi = 8'h00;
  bit f_wel = 0, f_stuck = 0;
  int f_left = 0, bitc = 0;
  logic [7:0] fsh, fout, fcmd, miso_r = 1'b0;
  logic [7:0] fbuf [$];
  logic [23:0] fa, pa;
  logic [7:0] t_cmd [0:63];
  logic [7:0] t_d1 [0:63];
  logic [23:0] t_adr [0:63];
  int t_size [0:63];
  int t_n = 0;
  assign spi_miso = miso_r[0];

  function automatic logic [7:0] f_status();
    return f_hi | {6'b0, f_wel, (f_left > 0) || f_stuck};
  endfunction

  function automatic logic [7:0] f_resp(input int k);
    logic [23:0] a;
    if (fbuf.size() == 0) return 8'h00;
    if (fbuf[0] == 8'h05) return f_status();
    if (fbuf[0] == 8'h03 && k >= 4) begin
      a = {fbuf[1], fbuf[2], fbuf[3]} + 24'(k - 4);
      return (a[23:10] == 0) ? f_mem[a[9:0]] : 8'hFF;
    end
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin bitc = 0; fbuf.delete(); miso_r = 8'h00; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    fsh = {fsh[6:0], spi_mosi}; bitc++;
    if (bitc % 8 == 0) fbuf.push_back(fsh);
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bitc % 8 == 0) fout = f_resp(bitc / 8); else fout = fout << 1;
    miso_r = {7'b0, fout[7]};
  end
  always @(posedge spi_cs_n) if (fbuf.size() > 0) begin
    fcmd = fbuf[0];
    fa = (fbuf.size() >= 4) ? {fbuf[1], fbuf[2], fbuf[3]} : 24'h0;
    if (t_n < 64) begin
      t_cmd[t_n] = fcmd; t_size[t_n] = fbuf.size(); t_adr[t_n] = fa;
      t_d1[t_n] = (fbuf.size() >= 2) ? fbuf[1] : 8'h00;
    end
    t_n++;
    case (fcmd)
      8'h06: f_wel = 1;
      8'h05: if (f_left > 0) f_left--;
      8'h02: if (f_wel) begin
        for (int k = 4; k < fbuf.size(); k++) begin
          pa = {fa[23:8], 8'(fa[7:0] + 8'(k - 4))};
          if (pa[23:10] == 0) f_mem[pa[9:0]] = f_mem[pa[9:0]] & fbuf[k];
        end
        f_wel = 0; f_left = BUSYN;
      end
      8'hD8: if (f_wel) begin
        if (fa[23:16] == 0) for (int i = 0; i < 1024; i++) f_mem[i] = 8'hFF;
        f_wel = 0; f_left = BUSYN;
      end
      8'hC7: if (f_wel) begin
        for (int i = 0; i < 1024; i++) f_mem[i] = 8'hFF;
        f_wel = 0; f_left = BUSYN;
      end
      8'h01: if (f_wel) begin f_hi = fbuf[1] & 8'hFC; f_wel = 0; f_left = BUSYN; end
      default: ;
    endcase
  end

  // ---------------- data side helpers ----------------
  logic [7:0] pbuf [0:15];
  int pptr = 0, take_n = 0;
  assign wr_data = pbuf[pptr % 16];
  always @(posedge clk) if (wr_take) begin pptr <= pptr + 1; take_n <= take_n + 1; end

  logic [7:0] rd_arr [0:255];
  int rd_n = 0, run = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin rd_arr[rd_n % 256] = rd_data; rd_n++; end
    check(!(!spi_cs_n && req_ready), "R10 ready low while selected", req_ready, 0);
    check(!(spi_cs_n && spi_sck), "R2 clock low while deselected", spi_sck, 0);
    if (spi_sck != sck_prev) begin
      if (sck_prev) check(run == HALF, "R2 high phase length", run, HALF);
      else          check(run >= HALF, "R2 low phase length", run, HALF);
      run = 1;
    end else run++;
    sck_prev = spi_sck;
  end

  task automatic do_req(input logic [2:0] op, input logic [23:0] a, input logic [8:0] n,
                        input logic [7:0] wd, output bit f, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = n; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done) begin @(negedge clk); cyc++; end
    f = fail;
    @(negedge clk);
    check(!done, "R10 done is one cycle", done, 0);
  endtask

  int b, r0, k0, cyc, np;
  bit f;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++; $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) f_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 reset chip select", spi_cs_n, 1);
    check(spi_sck == 1'b0, "R1 reset clock", spi_sck, 0);
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R9: status read, no write enable
    b = t_n; r0 = rd_n;
    do_req(3'd4, 24'h0, 9'd1, 8'h00, f, cyc);
    check(t_n - b == 1 && t_cmd[b] == 8'h05 && t_size[b] == 2, "R3 status read frame", t_cmd[b], 8'h05);
    check(rd_n - r0 == 1 && rd_arr[r0 % 256] == 8'h00, "R9 status byte", rd_arr[r0 % 256], 8'h00);

    // R4 R5: status write with enable and busy polling
    b = t_n;
    do_req(3'd5, 24'h0, 9'd1, 8'h1C, f, cyc);
    check(t_cmd[b] == 8'h06 && t_size[b] == 1, "R4 enable before status write", t_cmd[b], 8'h06);
    check(t_cmd[b+1] == 8'h01 && t_d1[b+1] == 8'h1C, "R4 status write bytes", t_d1[b+1], 8'h1C);
    np = 0;
    for (int i = b + 2; i < t_n; i++) if (t_cmd[i] == 8'h05) np++;
    check(np == BUSYN + 1 && t_n - b == BUSYN + 3, "R5 poll count", np, BUSYN + 1);
    check(f == 1'b0, "R5 success", f, 0);
    r0 = rd_n;
    do_req(3'd4, 24'h0, 9'd1, 8'h00, f, cyc);
    check(rd_arr[r0 % 256] == 8'h1C, "R9 status after write", rd_arr[r0 % 256], 8'h1C);

    // R8 R4: program 4 bytes
    pbuf[pptr % 16] = 8'hA5; pbuf[(pptr + 1) % 16] = 8'h3C;
    pbuf[(pptr + 2) % 16] = 8'h0F; pbuf[(pptr + 3) % 16] = 8'h81;
    b = t_n; k0 = take_n;
    do_req(3'd1, 24'h0000F0, 9'd4, 8'h00, f, cyc);
    check(take_n - k0 == 4, "R8 take count", take_n - k0, 4);
    check(t_cmd[b] == 8'h06 && t_cmd[b+1] == 8'h02, "R4 enable before program", t_cmd[b+1], 8'h02);
    check(t_adr[b+1] == 24'h0000F0 && t_size[b+1] == 8, "R4 program frame", t_adr[b+1], 24'h0000F0);
    check(f == 1'b0, "R5 program completes", f, 0);

    // R3 R9: read straddling the programmed bytes
    b = t_n; r0 = rd_n;
    do_req(3'd0, 24'h0000EF, 9'd6, 8'h00, f, cyc);
    check(t_cmd[b] == 8'h03 && t_adr[b] == 24'h0000EF && t_size[b] == 10, "R3 read frame", t_adr[b], 24'h0000EF);
    check(rd_n - r0 == 6, "R9 read byte count", rd_n - r0, 6);
    check(rd_arr[r0 % 256] == 8'hFF, "R9 byte0", rd_arr[r0 % 256], 8'hFF);
    check(rd_arr[(r0 + 1) % 256] == 8'hA5, "R9 byte1", rd_arr[(r0 + 1) % 256], 8'hA5);
    check(rd_arr[(r0 + 2) % 256] == 8'h3C, "R9 byte2", rd_arr[(r0 + 2) % 256], 8'h3C);
    check(rd_arr[(r0 + 3) % 256] == 8'h0F, "R9 byte3", rd_arr[(r0 + 3) % 256], 8'h0F);
    check(rd_arr[(r0 + 4) % 256] == 8'h81, "R9 byte4", rd_arr[(r0 + 4) % 256], 8'h81);
    check(rd_arr[(r0 + 5) % 256] == 8'hFF, "R9 byte5", rd_arr[(r0 + 5) % 256], 8'hFF);

    // R7: program ending exactly at page end is accepted
    pbuf[pptr % 16] = 8'h11; pbuf[(pptr + 1) % 16] = 8'h22;
    k0 = take_n;
    do_req(3'd1, 24'h0000FE, 9'd2, 8'h00, f, cyc);
    check(f == 1'b0 && take_n - k0 == 2, "R7 page-end program accepted", take_n - k0, 2);
    r0 = rd_n;
    do_req(3'd0, 24'h0000FE, 9'd2, 8'h00, f, cyc);
    check(rd_arr[r0 % 256] == 8'h11 && rd_arr[(r0 + 1) % 256] == 8'h22, "R8 data order", rd_arr[(r0 + 1) % 256], 8'h22);

    // R7: refusals
    b = t_n; k0 = take_n;
    do_req(3'd1, 24'h0001FF, 9'd2, 8'h00, f, cyc);
    check(f == 1'b1 && cyc == 1, "R7 page cross refused", cyc, 1);
    check(t_n == b && take_n == k0, "R7 no bus activity", t_n - b, 0);
    do_req(3'd0, 24'h000000, 9'd0, 8'h00, f, cyc);
    check(f == 1'b1 && t_n == b, "R7 zero-length read refused", f, 1);

    // R11: sector erase address is the sector base
    b = t_n;
    do_req(3'd2, 24'h05ABCD, 9'd0, 8'h00, f, cyc);
    check(t_cmd[b] == 8'h06 && t_cmd[b+1] == 8'hD8 && t_size[b+1] == 4, "R4 sector erase frame", t_cmd[b+1], 8'hD8);
    check(t_adr[b+1] == 24'h050000, "R11 sector base address", t_adr[b+1], 24'h050000);
    r0 = rd_n;
    do_req(3'd0, 24'h0000F0, 9'd1, 8'h00, f, cyc);
    check(rd_arr[r0 % 256] == 8'hA5, "R11 other sector kept", rd_arr[r0 % 256], 8'hA5);
    b = t_n;
    do_req(3'd2, 24'h001234, 9'd0, 8'h00, f, cyc);
    check(t_adr[b+1] == 24'h000000, "R11 sector zero base", t_adr[b+1], 24'h000000);
    r0 = rd_n;
    do_req(3'd0, 24'h0000F0, 9'd1, 8'h00, f, cyc);
    check(rd_arr[r0 % 256] == 8'hFF, "R11 sector erased", rd_arr[r0 % 256], 8'hFF);

    // R4: bulk erase is a lone opcode after enable
    b = t_n;
    do_req(3'd3, 24'h0, 9'd0, 8'h00, f, cyc);
    check(t_cmd[b] == 8'h06 && t_cmd[b+1] == 8'hC7 && t_size[b+1] == 1, "R4 bulk erase frame", t_cmd[b+1], 8'hC7);

    // R6: flash stuck busy
    f_stuck = 1;
    pbuf[pptr % 16] = 8'h5A;
    b = t_n;
    do_req(3'd1, 24'h000020, 9'd1, 8'h00, f, cyc);
    np = 0;
    for (int i = b + 2; i < t_n; i++) if (t_cmd[i] == 8'h05) np++;
    check(f == 1'b1, "R6 timeout fail", f, 1);
    check(np == PLIM, "R6 poll limit", np, PLIM);
    f_stuck = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule